// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits beside a small 8-bit CPU core and chooses which of five interrupt sources the core services next. The sources are, in fixed order, external event 0, timer 0, external event 1, timer 1, and a serial source. The serial source is active while either its receive flag or its transmit flag is set. Software programs a mask register and a level register through a simple write/read port. The block presents one request line, the level of that request and a 16-bit handler address to the core.

The core sends a single-cycle acceptance pulse when it takes the presented address, and a single-cycle return pulse when a handler finishes. The block keeps one in-service bit per level. A low-level handler can be interrupted only by a high-level request, and a high-level handler is never interrupted. Events that cannot be taken yet stay latched. Software can raise any request by writing its flag.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask, level and flag registers read 0 and `irq_req` is low.
- R2: Mask bit 7 is a global enable. A source is requested only when bit 7 and its own mask bit (bit index = source index 0..4) are both 1. A masked event stays latched and is requested once it is unmasked.
- R3: `reg_sel` selects the register: 0 = mask, 1 = level, 2 = flags, 3 = none (reads 0, writes ignored). Mask bits 6:5, level bits 7:5 and flag bits 7:6 read 0.
- R4: Among requests of the same level, the lowest source index wins.
- R5: A level bit of 1 puts its source at the high level, and any high request beats every low one.
- R6: The handler address is 0x0003 + 8 × source index: 0x0003, 0x000B, 0x0013, 0x001B, 0x0023.
- R7: `vec_ack` while `irq_req` is high marks that request's level in service and clears the latched flag of sources 0..3. `vec_ack` while `irq_req` is low has no effect.
- R8: While the low level is in service only high requests are presented. While the high level is in service no request is presented.
- R9: `reti` clears the high in-service bit if it is set, otherwise the low one.
- R10: The serial request is the OR of a receive flag (flag bit 4) and a transmit flag (flag bit 5). Acceptance never clears these flags; only a write to the flag register does.
- R11: Writing a 1 to a flag bit (bits 0..3 for sources 0..3) raises a request exactly like the hardware event.
- R12: `irq_level` is 1 when the presented request is at the high level, and 0 when it is at the low level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 mask, 1 level, 2 flags) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ev_hw | input | 4 | Event pulses for sources 0..3 |
| ser_rx_set | input | 1 | Sets the serial receive flag |
| ser_tx_set | input | 1 | Sets the serial transmit flag |
| vec_ack | input | 1 | CPU takes the presented address |
| reti | input | 1 | CPU returns from a handler |
| irq_req | output | 1 | Request to the CPU |
| irq_level | output | 1 | Level of the presented request |
| irq_vector | output | 16 | Handler address of the presented request |

## Verification
The hardest situation to reach is a nested one. A low handler must be in service when a high request arrives, and then `reti` must remove only the high level. The stimulus gets there in four steps. It accepts a low request first. It then raises a second source while that source is still low, and checks that the source stays hidden. Next it rewrites the level register so the pending source becomes high, and checks that it now preempts. Finally, after one `reti`, it checks that a fresh low event is still held back until a second `reti`.

// File: rtl/pirq_pkg.sv
`timescale 1ns/1ps
package pirq_pkg;
   typedef enum logic [1:0] {
      SEL_MASK  = 2'd0,
      SEL_LEVEL = 2'd1,
      SEL_FLAGS = 2'd2,
      SEL_NONE  = 2'd3
   } reg_sel_e;

   function automatic int unsigned vec_of(input int unsigned idx,
                                          input int unsigned base,
                                          input int unsigned stride);
      return base + idx * stride;
   endfunction
endpackage

// File: rtl/pirq_regs.sv
`timescale 1ns/1ps
module pirq_regs #(
   parameter int unsigned NSRC = 5,
   parameter int unsigned DW   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_mask,
   input  logic            wr_level,
   input  logic [DW-1:0]   wdata,
   output logic [NSRC-1:0] en_src,
   output logic            en_global,
   output logic [NSRC-1:0] level_hi,
   output logic [DW-1:0]   mask_rd
);
   localparam logic [DW-1:0] MASK_KEEP = (DW'(1) << (DW-1)) | DW'((1 << NSRC) - 1);

   if (NSRC + 1 > DW) begin : g_bad_width
      $error("pirq_regs: mask register too narrow for NSRC plus global bit");
   end

   logic [DW-1:0]   mask_q;
   logic [NSRC-1:0] level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (wr_mask) begin
         mask_q <= wdata & MASK_KEEP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
      end else if (wr_level) begin
         level_q <= wdata[NSRC-1:0];
      end
   end

   assign en_src    = mask_q[NSRC-1:0];
   assign en_global = mask_q[DW-1];
   assign level_hi  = level_q;
   assign mask_rd   = mask_q;
endmodule

// File: rtl/pirq_flags.sv
`timescale 1ns/1ps
module pirq_flags #(
   parameter int unsigned NSRC = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-2:0] hw_evt,
   input  logic            rx_evt,
   input  logic            tx_evt,
   input  logic            sw_wr,
   input  logic [NSRC:0]   sw_data,
   input  logic [NSRC-2:0] ack_clr,
   output logic [NSRC-1:0] pend,
   output logic [NSRC:0]   flag_rd
);
   localparam int unsigned NLATCH = NSRC - 1;

   logic [NLATCH-1:0] lat_q;
   logic              rx_q;
   logic              tx_q;

   for (genvar i = 0; i < NLATCH; i++) begin : g_latch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lat_q[i] <= 1'b0;
         end else if (hw_evt[i]) begin
            lat_q[i] <= 1'b1;
         end else if (sw_wr) begin
            lat_q[i] <= sw_data[i];
         end else if (ack_clr[i]) begin
            lat_q[i] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q <= 1'b0;
         tx_q <= 1'b0;
      end else begin
         if (rx_evt) begin
            rx_q <= 1'b1;
         end else if (sw_wr) begin
            rx_q <= sw_data[NLATCH];
         end
         if (tx_evt) begin
            tx_q <= 1'b1;
         end else if (sw_wr) begin
            tx_q <= sw_data[NLATCH+1];
         end
      end
   end

   assign pend    = {rx_q | tx_q, lat_q};
   assign flag_rd = {tx_q, rx_q, lat_q};
endmodule

// File: rtl/pirq_arbiter.sv
`timescale 1ns/1ps
module pirq_arbiter #(
   parameter int unsigned NSRC = 5
) (
   input  logic [NSRC-1:0] cand,
   output logic [NSRC-1:0] grant,
   output logic            any
);
   logic [NSRC:0] seen;

   assign seen[0] = 1'b0;
   for (genvar i = 0; i < NSRC; i++) begin : g_chain
      assign grant[i]  = cand[i] & ~seen[i];
      assign seen[i+1] = seen[i] | cand[i];
   end
   assign any = seen[NSRC];
endmodule

// File: rtl/pirq_svc.sv
`timescale 1ns/1ps
module pirq_svc (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic take_hi,
   input  logic ret,
   output logic svc_hi,
   output logic svc_lo
);
   logic hi_q, lo_q;
   logic clr_hi, clr_lo;

   assign clr_hi = ret & hi_q;
   assign clr_lo = ret & ~hi_q & lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= 1'b0;
         lo_q <= 1'b0;
      end else begin
         hi_q <= (hi_q & ~clr_hi) | (take & take_hi);
         lo_q <= (lo_q & ~clr_lo) | (take & ~take_hi);
      end
   end

   assign svc_hi = hi_q;
   assign svc_lo = lo_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl #(
   parameter int unsigned NSRC       = 5,
   parameter int unsigned DW         = 8,
   parameter int unsigned VEC_W      = 16,
   parameter int unsigned VEC_BASE   = 3,
   parameter int unsigned VEC_STRIDE = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   input  logic [NSRC-2:0]   ev_hw,
   input  logic              ser_rx_set,
   input  logic              ser_tx_set,
   input  logic              vec_ack,
   input  logic              reti,
   output logic              irq_req,
   output logic              irq_level,
   output logic [VEC_W-1:0]  irq_vector
);
   import pirq_pkg::*;

   if (NSRC < 2 || NSRC + 1 > DW) begin : g_bad_nsrc
      $error("prio_irq_ctrl: NSRC must be at least 2 and leave room for two serial flags");
   end
   if (pirq_pkg::vec_of(NSRC - 1, VEC_BASE, VEC_STRIDE) >= (1 << VEC_W)) begin : g_bad_vec
      $error("prio_irq_ctrl: handler addresses exceed VEC_W");
   end

   reg_sel_e sel;
   assign sel = reg_sel_e'(reg_sel);

   logic [NSRC-1:0] en_src, level_hi, pend;
   logic            en_global;
   logic [DW-1:0]   mask_rd;
   logic [NSRC:0]   flag_rd;
   logic [NSRC-2:0] ack_clr;

   pirq_regs #(.NSRC(NSRC), .DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_mask(reg_wr && sel == SEL_MASK),
      .wr_level(reg_wr && sel == SEL_LEVEL),
      .wdata(reg_wdata),
      .en_src(en_src), .en_global(en_global),
      .level_hi(level_hi), .mask_rd(mask_rd)
   );

   pirq_flags #(.NSRC(NSRC)) u_flags (
      .clk(clk), .rst_n(rst_n),
      .hw_evt(ev_hw), .rx_evt(ser_rx_set), .tx_evt(ser_tx_set),
      .sw_wr(reg_wr && sel == SEL_FLAGS),
      .sw_data(reg_wdata[NSRC:0]),
      .ack_clr(ack_clr),
      .pend(pend), .flag_rd(flag_rd)
   );

   logic [NSRC-1:0] cand, cand_hi, cand_lo, grant_hi, grant_lo, grant;
   logic            any_hi, any_lo, pick_hi, pick_lo;
   logic            svc_hi, svc_lo, take;

   assign cand    = pend & en_src & {NSRC{en_global}};
   assign cand_hi = cand & level_hi;
   assign cand_lo = cand & ~level_hi;

   pirq_arbiter #(.NSRC(NSRC)) u_arb_hi (.cand(cand_hi), .grant(grant_hi), .any(any_hi));
   pirq_arbiter #(.NSRC(NSRC)) u_arb_lo (.cand(cand_lo), .grant(grant_lo), .any(any_lo));

   assign pick_hi = ~svc_hi & any_hi;
   assign pick_lo = ~svc_hi & ~svc_lo & ~any_hi & any_lo;
   assign grant   = pick_hi ? grant_hi : (pick_lo ? grant_lo : '0);

   assign irq_req   = pick_hi | pick_lo;
   assign irq_level = pick_hi;
   assign take      = vec_ack & irq_req;
   assign ack_clr   = take ? grant[NSRC-2:0] : '0;

   pirq_svc u_svc (
      .clk(clk), .rst_n(rst_n),
      .take(take), .take_hi(pick_hi), .ret(reti),
      .svc_hi(svc_hi), .svc_lo(svc_lo)
   );

   logic [VEC_W-1:0] vec_term [NSRC];
   for (genvar i = 0; i < NSRC; i++) begin : g_vec
      localparam logic [VEC_W-1:0] ADDR = VEC_W'(pirq_pkg::vec_of(i, VEC_BASE, VEC_STRIDE));
      assign vec_term[i] = grant[i] ? ADDR : '0;
   end

   always_comb begin
      irq_vector = '0;
      for (int i = 0; i < NSRC; i++) begin
         irq_vector = irq_vector | vec_term[i];
      end
   end

   always_comb begin
      case (sel)
         SEL_MASK:  reg_rdata = mask_rd;
         SEL_LEVEL: reg_rdata = DW'(level_hi);
         SEL_FLAGS: reg_rdata = DW'(flag_rd);
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/pirq_checker.sv
`timescale 1ns/1ps
module pirq_checker #(
   parameter int unsigned NSRC = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            irq_req,
   input logic            irq_level,
   input logic            vec_ack,
   input logic            reti,
   input logic            reg_wr,
   input logic [1:0]      reg_sel,
   input logic            en_global,
   input logic            svc_hi,
   input logic            svc_lo,
   input logic [NSRC:0]   flag_rd,
   input logic [NSRC-1:0] grant
);
   localparam int unsigned RX_BIT = NSRC - 1;
   localparam int unsigned TX_BIT = NSRC;

   assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> en_global);

   assert_one_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && (irq_req == (grant != '0)));

   assert_ack_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_ack && irq_req && !irq_level && !reti) |=> svc_lo);

   assert_ack_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_ack && irq_req && irq_level) |=> svc_hi);

   assert_hi_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      svc_hi |-> !irq_req);

   assert_lo_only_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_lo && irq_req) |-> irq_level);

   assert_reti_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && svc_hi && !vec_ack) |=> (!svc_hi && $stable(svc_lo)));

   assert_serial_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_rd[RX_BIT] && !(reg_wr && reg_sel == 2'd2)) |=> flag_rd[RX_BIT]);

   assert_serial_tx_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_rd[TX_BIT] && !(reg_wr && reg_sel == 2'd2)) |=> flag_rd[TX_BIT]);
endmodule

bind prio_irq_ctrl pirq_checker #(.NSRC(NSRC)) u_pirq_checker (
   .clk(clk), .rst_n(rst_n),
   .irq_req(irq_req), .irq_level(irq_level),
   .vec_ack(vec_ack), .reti(reti),
   .reg_wr(reg_wr), .reg_sel(reg_sel),
   .en_global(en_global),
   .svc_hi(svc_hi), .svc_lo(svc_lo),
   .flag_rd(flag_rd), .grant(grant)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;
   logic [3:0]  ev_hw = 4'b0;
   logic        ser_rx_set = 1'b0;
   logic        ser_tx_set = 1'b0;
   logic        vec_ack = 1'b0;
   logic        reti = 1'b0;
   logic        irq_req;
   logic        irq_level;
   logic [15:0] irq_vector;

   always #2.5 clk = ~clk;

   prio_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ev_hw(ev_hw), .ser_rx_set(ser_rx_set), .ser_tx_set(ser_tx_set),
      .vec_ack(vec_ack), .reti(reti),
      .irq_req(irq_req), .irq_level(irq_level), .irq_vector(irq_vector)
   );

   typedef struct {
      bit          is_read;
      logic        req;
      logic [15:0] vec;
      logic        lvl;
      logic [7:0]  data;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_checks = 0;
   int   n_fail   = 0;

   // monitor: pops one expectation per falling edge and compares
   always @(negedge clk) begin
      if (exp_q.size() != 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_checks++;
         if (e.is_read) begin
            if (reg_rdata !== e.data) begin
               n_fail++;
               $display("FAIL %s: rdata=%02h expected %02h", e.tag, reg_rdata, e.data);
            end
         end else if (irq_req !== e.req ||
                      (e.req && (irq_vector !== e.vec || irq_level !== e.lvl))) begin
            n_fail++;
            $display("FAIL %s: req=%0b vec=%04h lvl=%0b expected req=%0b vec=%04h lvl=%0b",
                     e.tag, irq_req, irq_vector, irq_level, e.req, e.vec, e.lvl);
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
      ev_hw = '0; ser_rx_set = 0; ser_tx_set = 0;
      vec_ack = 0; reti = 0; reg_wr = 0;
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] d);
      reg_sel = sel; reg_wdata = d; reg_wr = 1; tick();
   endtask

   task automatic pulse_hw(input logic [3:0] m);
      ev_hw = m; tick();
   endtask

   task automatic do_ack();  vec_ack = 1; tick(); endtask
   task automatic do_reti(); reti = 1;    tick(); endtask

   task automatic chk_irq(input logic r, input logic [15:0] v, input logic l, input string tag);
      exp_t e;
      e.is_read = 0; e.req = r; e.vec = v; e.lvl = l; e.data = '0; e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk); #1;
   endtask

   task automatic chk_rd(input logic [1:0] sel, input logic [7:0] d, input string tag);
      exp_t e;
      reg_sel = sel;
      e.is_read = 1; e.req = 0; e.vec = '0; e.lvl = 0; e.data = d; e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk); #1;
   endtask

   initial begin
      #(2_000_000);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      chk_irq(0, 16'h0, 0, "R1 no request after reset");
      chk_rd(2'd0, 8'h00, "R1 mask reset");
      chk_rd(2'd1, 8'h00, "R1 level reset");
      chk_rd(2'd2, 8'h00, "R1 flags reset");

      // R2 global enable and latching while masked
      wr(2'd0, 8'h01);
      pulse_hw(4'b0001);
      chk_irq(0, 16'h0, 0, "R2 individual bit without global");
      wr(2'd0, 8'h81);
      chk_irq(1, 16'h0003, 0, "R2 latched event taken after unmask");
      do_ack();
      chk_irq(0, 16'h0, 0, "R7 accepted request cleared");
      do_reti();

      // R3 reserved bits and select 3
      wr(2'd0, 8'hFF);
      chk_rd(2'd0, 8'h9F, "R3 mask reserved bits");
      wr(2'd1, 8'hFF);
      chk_rd(2'd1, 8'h1F, "R3 level reserved bits");
      wr(2'd3, 8'hFF);
      chk_rd(2'd3, 8'h00, "R3 select 3 reads zero");
      wr(2'd1, 8'h00);
      chk_rd(2'd2, 8'h00, "R3 select 3 write ignored by flags");

      // R4 fixed order at low level, R6 addresses
      pulse_hw(4'b1110);
      chk_irq(1, 16'h000B, 0, "R4 timer0 before ext1 and timer1");
      do_ack();
      chk_irq(0, 16'h0, 0, "R8 low not preempted by low");
      do_reti();
      chk_irq(1, 16'h0013, 0, "R6 ext1 address");
      do_ack(); do_reti();
      chk_irq(1, 16'h001B, 0, "R6 timer1 address");
      do_ack(); do_reti();
      chk_irq(0, 16'h0, 0, "R4 all served");

      // R5 high beats low, R12 level output
      wr(2'd1, 8'h08);
      pulse_hw(4'b1001);
      chk_irq(1, 16'h001B, 1, "R5 high timer1 over low ext0 R12");
      do_ack();
      chk_irq(0, 16'h0, 0, "R8 nothing while high in service");
      do_reti();
      chk_irq(1, 16'h0003, 0, "R9 high cleared, low ext0 shown R12");

      // nesting: low in service, then high preempts
      do_ack();
      pulse_hw(4'b0010);
      chk_irq(0, 16'h0, 0, "R8 low timer0 held during low service");
      wr(2'd1, 8'h0A);
      chk_irq(1, 16'h000B, 1, "R8 high timer0 preempts low service");
      do_ack();
      chk_irq(0, 16'h0, 0, "R8 both levels busy");
      do_reti();
      pulse_hw(4'b0100);
      chk_irq(0, 16'h0, 0, "R9 first return leaves low in service");
      do_reti();
      chk_irq(1, 16'h0013, 0, "R9 second return frees low");
      do_ack(); do_reti();
      chk_irq(0, 16'h0, 0, "R9 idle again");

      // R10 serial
      wr(2'd1, 8'h00);
      ser_rx_set = 1; tick();
      chk_irq(1, 16'h0023, 0, "R10 receive flag R6 serial address");
      do_ack();
      chk_rd(2'd2, 8'h10, "R10 receive flag kept after accept");
      do_reti();
      chk_irq(1, 16'h0023, 0, "R10 serial requests again");
      wr(2'd2, 8'h00);
      chk_irq(0, 16'h0, 0, "R10 software clear");
      ser_tx_set = 1; tick();
      chk_irq(1, 16'h0023, 0, "R10 transmit flag");
      chk_rd(2'd2, 8'h20, "R10 transmit flag bit");
      wr(2'd2, 8'h00);
      chk_irq(0, 16'h0, 0, "R10 transmit cleared");

      // R11 software trigger
      wr(2'd2, 8'h04);
      chk_irq(1, 16'h0013, 0, "R11 software raised ext1");
      chk_rd(2'd2, 8'h04, "R11 flag reads back");
      do_ack();
      chk_rd(2'd2, 8'h00, "R7 accept clears latched flag");
      do_reti();

      // R7 accept with no request ignored
      do_ack();
      pulse_hw(4'b0001);
      chk_irq(1, 16'h0003, 0, "R7 stray accept ignored");
      do_ack(); do_reti();

      // R2 global off with software flag
      wr(2'd0, 8'h1F);
      wr(2'd2, 8'h01);
      chk_irq(0, 16'h0, 0, "R2 global off blocks software flag");
      wr(2'd0, 8'h9F);
      chk_irq(1, 16'h0003, 0, "R2 global on releases it");

      repeat (2) @(posedge clk);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule